// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

This block is a programmable supervision timer. Once software sets the run bit, a down-counter starts from a programmed timeout value. Software must service it in time by writing a two-word key pair to the service register. A correct pair reloads the counter from the timeout register. When the counter expires, the block either raises an interrupt or requests a system reset; the choice is programmable. An expiry that arrives while the interrupt from the previous expiry is still pending always requests a reset. In window mode, a service write made too early (while the count is still above the window value) is treated as a fault and also requests a reset.

A simple single-cycle register port is used for access. Each access carries a master identifier, and an 8-bit enable field in the control word decides which masters may use the port. Refused accesses flag an error, change nothing and read as zero. A soft lock and a hard lock freeze the configuration registers. The soft lock can be removed with its own key pair. The hard lock stays set until the next system reset. Two status inputs can stall the count: one for debug and one for stop mode, each gated by its own control bit. The reset request output is sticky; the surrounding reset controller is expected to act on it and reset the block.

Register map (word index on `bus_addr`): 0 control, 1 timeout, 2 window, 3 service, 4 status, 5 counter (read only), 6 lock key. Control word bits: [0] run, [1] interrupt-on-first-expiry, [2] window mode, [3] debug freeze, [4] stop halt, [5] soft lock, [6] hard lock, [15:8] master enable (bit `8+id` for master `id`).

Top module: `guard_timer`

## Requirements
- R1: After reset, irq_o and rst_req_o are 0, the control word reads 0x0000FF00 (not running, every master enabled, unlocked), and the timeout register reads the TO_RST parameter (default 4096).
- R2: While running and not stalled, the counter (index 5) drops by one per clock from the timeout value, and the first expiry takes effect T+1 clocks after the enabling write for timeout T, then the counter reloads to T. With control bit 1 set, that first expiry sets irq_o and leaves rst_req_o low.
- R3: With control bit 1 clear, the first expiry sets rst_req_o, and rst_req_o stays high until system reset.
- R4: An expiry that occurs while the interrupt flag is still pending sets rst_req_o, whatever control bit 1 holds.
- R5: Writing 0xA602 and then 0xB480 (low 16 bits) to the service register reloads the counter with the timeout value and clears the interrupt flag; if any other word follows 0xA602, there is no reload.
- R6: Writing 1 to status bit 0 clears the interrupt flag without reloading the counter, and the next expiry after that gives an interrupt again, not a reset.
- R7: With control bit 2 set, any service-register write while the counter is greater than the window register sets rst_req_o; writes at or below the window value are accepted normally.
- R8: With control bit 3 set, the counter holds while dbg_mode is high; with it clear, the counter keeps running in debug.
- R9: With control bit 4 set, the counter holds while stop_mode is high.
- R10: A set soft lock (control bit 5) ignores writes to control, timeout and window; writing 0xC520 and then 0xD928 to the lock-key register clears it, and any other second word does not.
- R11: A set hard lock (control bit 6) ignores writes to control, timeout and window, is not cleared by the unlock key pair, and is cleared only by reset.
- R12: An access from a master whose bit in control[15:8] is 0 raises bus_err in the same cycle, writes nothing and returns 0 on bus_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_mid | input | 3 | Identifier of the requesting master |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access refused for this master |
| dbg_mode | input | 1 | Debug-state indication |
| stop_mode | input | 1 | Stop-state indication |
| irq_o | output | 1 | Interrupt flag from a first expiry |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
Read data and bus_err are combinational within the access cycle, so the bench samples them 2 ns after it drives the request and does not wait for an edge. A write takes effect at the clock edge that ends its cycle. The bench returns from each write on the following falling edge and reads its effect there. Counter values and expiry outputs are checked by counting falling edges after that write. The counter reaches T minus k after k edges, the first expiry shows after T+1 edges, and a service pair leaves the counter at T right after its second write. Stall checks compare the counter before and after a known number of edges.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;
  localparam int CFG_W  = 7;
  localparam int MEN_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_TIMEOUT = 3'd1,
    REG_WINDOW  = 3'd2,
    REG_SERVICE = 3'd3,
    REG_STATUS  = 3'd4,
    REG_COUNT   = 3'd5,
    REG_LOCKKEY = 3'd6
  } reg_idx_e;

  localparam logic [KEY_W-1:0] SVC_KEY_FIRST  = 16'hA602;
  localparam logic [KEY_W-1:0] SVC_KEY_SECOND = 16'hB480;
  localparam logic [KEY_W-1:0] UNL_KEY_FIRST  = 16'hC520;
  localparam logic [KEY_W-1:0] UNL_KEY_SECOND = 16'hD928;

  // control word, bit 0 is the last member
  typedef struct packed {
    logic hard_lock;
    logic soft_lock;
    logic stop_halt;
    logic dbg_freeze;
    logic win_en;
    logic irq_first;
    logic run;
  } cfg_t;

endpackage

// File: rtl/guard_timer_rstsync.sv
module guard_timer_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/guard_timer_regs.sv
module guard_timer_regs
  import guard_timer_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          MID_W   = 3,
  parameter logic [31:0] TO_RST  = 32'd4096,
  parameter logic [31:0] WIN_RST = 32'd0
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [MID_W-1:0]    bus_mid,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                irq_i,
  output cfg_t                cfg_o,
  output logic [CNT_W-1:0]    timeout_o,
  output logic                svc_done_o,
  output logic                win_viol_o,
  output logic                irq_clr_o
);

  localparam int NMST = 1 << MID_W;

  cfg_t             cfg_q, cfg_d;
  logic [NMST-1:0]  men_q, men_d;
  logic [CNT_W-1:0] timeout_q, timeout_d;
  logic [CNT_W-1:0] window_q, window_d;
  logic             svc_arm_q, svc_arm_d;
  logic             unl_arm_q, unl_arm_d;

  logic             cfg_we, to_we, win_we, seq_we;
  logic             accepted, wr_ok, locked;
  logic [KEY_W-1:0] key;

  assign accepted = bus_valid & men_q[bus_mid];
  assign wr_ok    = accepted & bus_write;
  assign locked   = cfg_q.soft_lock | cfg_q.hard_lock;
  assign key      = bus_wdata[KEY_W-1:0];
  assign bus_err  = bus_valid & ~men_q[bus_mid];

  // next-state logic
  always_comb begin
    cfg_d      = cfg_q;
    men_d      = men_q;
    timeout_d  = timeout_q;
    window_d   = window_q;
    svc_arm_d  = svc_arm_q;
    unl_arm_d  = unl_arm_q;
    cfg_we     = 1'b0;
    to_we      = 1'b0;
    win_we     = 1'b0;
    seq_we     = 1'b0;
    svc_done_o = 1'b0;
    win_viol_o = 1'b0;
    irq_clr_o  = 1'b0;
    if (wr_ok) begin
      case (bus_addr)
        REG_CTRL: begin
          if (!locked) begin
            cfg_d  = cfg_t'(bus_wdata[CFG_W-1:0]);
            men_d  = bus_wdata[MEN_LSB +: NMST];
            cfg_we = 1'b1;
          end
        end
        REG_TIMEOUT: begin
          if (!locked) begin
            timeout_d = bus_wdata[CNT_W-1:0];
            to_we     = 1'b1;
          end
        end
        REG_WINDOW: begin
          if (!locked) begin
            window_d = bus_wdata[CNT_W-1:0];
            win_we   = 1'b1;
          end
        end
        REG_SERVICE: begin
          seq_we = 1'b1;
          if (cfg_q.win_en && (cnt_i > window_q)) begin
            win_viol_o = 1'b1;
          end
          if (svc_arm_q && (key == SVC_KEY_SECOND)) begin
            svc_done_o = 1'b1;
            svc_arm_d  = 1'b0;
          end else begin
            svc_arm_d = (key == SVC_KEY_FIRST);
          end
        end
        REG_STATUS: begin
          irq_clr_o = bus_wdata[0];
        end
        REG_LOCKKEY: begin
          seq_we = 1'b1;
          if (unl_arm_q && (key == UNL_KEY_SECOND)) begin
            cfg_d.soft_lock = 1'b0;
            cfg_we          = 1'b1;
            unl_arm_d       = 1'b0;
          end else begin
            unl_arm_d = (key == UNL_KEY_FIRST);
          end
        end
        default: begin
        end
      endcase
    end
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      men_q     <= '1;
      timeout_q <= TO_RST[CNT_W-1:0];
      window_q  <= WIN_RST[CNT_W-1:0];
      svc_arm_q <= 1'b0;
      unl_arm_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q <= cfg_d;
        men_q <= men_d;
      end
      if (to_we) begin
        timeout_q <= timeout_d;
      end
      if (win_we) begin
        window_q <= window_d;
      end
      if (seq_we) begin
        svc_arm_q <= svc_arm_d;
        unl_arm_q <= unl_arm_d;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (accepted && !bus_write) begin
      case (bus_addr)
        REG_CTRL: begin
          bus_rdata[CFG_W-1:0]       = cfg_q;
          bus_rdata[MEN_LSB +: NMST] = men_q;
        end
        REG_TIMEOUT: bus_rdata[CNT_W-1:0] = timeout_q;
        REG_WINDOW:  bus_rdata[CNT_W-1:0] = window_q;
        REG_STATUS:  bus_rdata[0]         = irq_i;
        REG_COUNT:   bus_rdata[CNT_W-1:0] = cnt_i;
        default:     bus_rdata            = '0;
      endcase
    end
  end

  assign cfg_o     = cfg_q;
  assign timeout_o = timeout_q;

  AST_LOCK_KEEPS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_ni)
    locked |=> $stable(timeout_q)); // R10

  AST_LOCK_KEEPS_WINDOW: assert property (@(posedge clk) disable iff (!rst_ni)
    locked |=> $stable(window_q)); // R10

  AST_HARD_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_q.hard_lock |=> cfg_q.hard_lock); // R11

  AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_valid && !men_q[bus_mid]) |=> ($stable(cfg_q) && $stable(timeout_q) && $stable(window_q))); // R12

  AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_err |-> (bus_rdata == '0)); // R12

endmodule

// File: rtl/guard_timer_count.sv
module guard_timer_count
  import guard_timer_pkg::*;
#(
  parameter int          CNT_W  = 32,
  parameter logic [31:0] TO_RST = 32'd4096
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             dbg_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             svc_done_i,
  input  logic             win_viol_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_req_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             rst_req_q, rst_req_d;
  logic             cnt_we, tick, at_zero, expire;

  assign tick    = cfg_i.run
                 & ~(cfg_i.dbg_freeze & dbg_i)
                 & ~(cfg_i.stop_halt & stop_i);
  assign at_zero = (cnt_q == '0);
  assign expire  = tick & at_zero & ~svc_done_i;

  // counter next state
  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (!cfg_i.run || svc_done_i) begin
      cnt_d  = timeout_i;
      cnt_we = 1'b1;
    end else if (tick) begin
      cnt_we = 1'b1;
      if (at_zero) begin
        cnt_d = timeout_i;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // escalation next state
  always_comb begin
    irq_d = irq_q;
    if (irq_clr_i) begin
      irq_d = 1'b0;
    end
    if (expire && cfg_i.irq_first && !irq_q) begin
      irq_d = 1'b1;
    end
    if (svc_done_i) begin
      irq_d = 1'b0;
    end
    rst_req_d = rst_req_q
              | win_viol_i
              | (expire & (irq_q | ~cfg_i.irq_first));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= TO_RST[CNT_W-1:0];
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (cnt_we) begin
        cnt_q <= cnt_d;
      end
      irq_q     <= irq_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_req_q;

  AST_SECOND_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire && irq_q) |=> rst_req_q); // R4

  AST_RESET_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req_q |=> rst_req_q); // R3

  AST_SERVICE_RELOADS: assert property (@(posedge clk) disable iff (!rst_ni)
    svc_done_i |=> (cnt_q == $past(timeout_i))); // R5

  AST_DEBUG_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_i.run && cfg_i.dbg_freeze && dbg_i && !svc_done_i) |=> $stable(cnt_q)); // R8

  AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_i.run && cfg_i.stop_halt && stop_i && !svc_done_i) |=> $stable(cnt_q)); // R9

  AST_FIRST_EXPIRY_IRQ: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire && cfg_i.irq_first && !irq_q && !rst_req_q && !win_viol_i) |=> (irq_q && !rst_req_q)); // R2

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          MID_W    = 3,
  parameter int          SYNC_STG = 2,
  parameter logic [31:0] TO_RST   = 32'd4096,
  parameter logic [31:0] WIN_RST  = 32'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_mid,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              dbg_mode,
  input  logic              stop_mode,
  output logic              irq_o,
  output logic              rst_req_o
);

  logic             rst_sync_n;
  cfg_t             cfg;
  logic [CNT_W-1:0] timeout, cnt;
  logic             svc_done, win_viol, irq_clr, irq_flag;

  guard_timer_rstsync #(
    .STAGES (SYNC_STG)
  ) u_rstsync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  guard_timer_regs #(
    .CNT_W   (CNT_W),
    .MID_W   (MID_W),
    .TO_RST  (TO_RST),
    .WIN_RST (WIN_RST)
  ) u_regs (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_mid    (bus_mid),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .cnt_i      (cnt),
    .irq_i      (irq_flag),
    .cfg_o      (cfg),
    .timeout_o  (timeout),
    .svc_done_o (svc_done),
    .win_viol_o (win_viol),
    .irq_clr_o  (irq_clr)
  );

  guard_timer_count #(
    .CNT_W  (CNT_W),
    .TO_RST (TO_RST)
  ) u_count (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .cfg_i      (cfg),
    .dbg_i      (dbg_mode),
    .stop_i     (stop_mode),
    .timeout_i  (timeout),
    .svc_done_i (svc_done),
    .win_viol_i (win_viol),
    .irq_clr_i  (irq_clr),
    .cnt_o      (cnt),
    .irq_o      (irq_flag),
    .rst_req_o  (rst_req_o)
  );

  assign irq_o = irq_flag;

  AST_EARLY_SERVICE_RESETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_viol |=> rst_req_o); // R7

  AST_UNSERVICED_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_flag && !svc_done && !irq_clr) |=> irq_o); // R6

endmodule

// File: tb/tb_guard_timer.sv
module tb_guard_timer;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TO   = 3'd1;
  localparam logic [2:0] A_WIN  = 3'd2;
  localparam logic [2:0] A_SVC  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_CNT  = 3'd5;
  localparam logic [2:0] A_KEY  = 3'd6;
  localparam logic [31:0] TO_DEF = 32'd4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_mid = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        dbg_mode = 1'b0;
  logic        stop_mode = 1'b0;
  logic        irq_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;
  logic last_err;

  always #10 clk = ~clk;

  guard_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_mid   (bus_mid),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .dbg_mode  (dbg_mode),
    .stop_mode (stop_mode),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // entered and left on a falling edge; the write lands on the edge in between
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [2:0] m = 3'd0);
    bus_valid = 1'b1;
    bus_write = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    bus_mid   = m;
    #2;
    last_err = bus_err;
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d,
                    input logic [2:0] m = 3'd0);
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = a;
    bus_mid   = m;
    #2;
    d = bus_rdata;
    last_err = bus_err;
    bus_valid = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    dbg_mode = 1'b0;
    stop_mode = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    do_reset();
    check("R1", "irq after reset", {31'd0, irq_o}, 32'd0);
    check("R1", "rst_req after reset", {31'd0, rst_req_o}, 32'd0);
    rd(A_CTRL, v);
    check("R1", "control word", v, 32'h0000FF00);
    rd(A_TO, v);
    check("R1", "timeout", v, TO_DEF);
  endtask

  task automatic t_first_irq;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF03);
    idle(3);
    rd(A_CNT, v);
    check("R2", "count after 3 clocks", v, 32'd7);
    idle(7);
    check("R2", "irq before expiry", {31'd0, irq_o}, 32'd0);
    idle(1);
    check("R2", "irq at first expiry", {31'd0, irq_o}, 32'd1);
    check("R2", "no reset at first expiry", {31'd0, rst_req_o}, 32'd0);
    rd(A_CNT, v);
    check("R2", "reload after expiry", v, 32'd10);
    idle(11);
    check("R4", "second expiry resets", {31'd0, rst_req_o}, 32'd1);
  endtask

  task automatic t_reset_first;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF01);
    idle(11);
    check("R3", "reset on first expiry", {31'd0, rst_req_o}, 32'd1);
    check("R3", "no irq in reset mode", {31'd0, irq_o}, 32'd0);
    idle(5);
    check("R3", "reset request sticky", {31'd0, rst_req_o}, 32'd1);
  endtask

  task automatic t_service;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF03);
    idle(5);
    wr(A_SVC, 32'h0000A602);
    wr(A_SVC, 32'h0000B480);
    rd(A_CNT, v);
    check("R5", "count after key pair", v, 32'd10);
    wr(A_SVC, 32'h0000A602);
    wr(A_SVC, 32'h00001234);
    rd(A_CNT, v);
    check("R5", "no reload on wrong second key", v, 32'd8);
    idle(9);
    check("R5", "irq pending before service", {31'd0, irq_o}, 32'd1);
    wr(A_SVC, 32'h0000A602);
    wr(A_SVC, 32'h0000B480);
    check("R5", "service clears irq", {31'd0, irq_o}, 32'd0);
    rd(A_CNT, v);
    check("R5", "reload while irq pending", v, 32'd10);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF03);
    idle(11);
    rd(A_STAT, v);
    check("R6", "status shows irq", v, 32'd1);
    wr(A_STAT, 32'd1);
    check("R6", "irq cleared", {31'd0, irq_o}, 32'd0);
    rd(A_CNT, v);
    check("R6", "clear does not reload", v, 32'd9);
    idle(10);
    check("R6", "next expiry is irq", {31'd0, irq_o}, 32'd1);
    check("R6", "next expiry not reset", {31'd0, rst_req_o}, 32'd0);
  endtask

  task automatic t_window;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd20);
    wr(A_WIN, 32'd8);
    wr(A_CTRL, 32'h0000FF07);
    idle(3);
    wr(A_SVC, 32'h0000A602);
    check("R7", "early service resets", {31'd0, rst_req_o}, 32'd1);
    do_reset();
    wr(A_TO, 32'd20);
    wr(A_WIN, 32'd8);
    wr(A_CTRL, 32'h0000FF07);
    idle(12);
    rd(A_CNT, v);
    check("R7", "count at window edge", v, 32'd8);
    wr(A_SVC, 32'h0000A602);
    wr(A_SVC, 32'h0000B480);
    check("R7", "service inside window no reset", {31'd0, rst_req_o}, 32'd0);
    rd(A_CNT, v);
    check("R7", "service inside window reloads", v, 32'd20);
  endtask

  task automatic t_debug;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF0B);
    idle(2);
    dbg_mode = 1'b1;
    idle(4);
    rd(A_CNT, v);
    check("R8", "frozen in debug", v, 32'd8);
    dbg_mode = 1'b0;
    idle(2);
    rd(A_CNT, v);
    check("R8", "runs after debug", v, 32'd6);
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF03);
    dbg_mode = 1'b1;
    idle(3);
    rd(A_CNT, v);
    check("R8", "runs in debug without freeze", v, 32'd7);
    dbg_mode = 1'b0;
  endtask

  task automatic t_stop;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF13);
    idle(2);
    stop_mode = 1'b1;
    idle(4);
    rd(A_CNT, v);
    check("R9", "halted in stop", v, 32'd8);
    stop_mode = 1'b0;
    idle(1);
    rd(A_CNT, v);
    check("R9", "runs after stop", v, 32'd7);
  endtask

  task automatic t_soft_lock;
    logic [31:0] v;
    do_reset();
    wr(A_TO, 32'd10);
    wr(A_CTRL, 32'h0000FF20);
    wr(A_TO, 32'd50);
    rd(A_TO, v);
    check("R10", "timeout locked", v, 32'd10);
    wr(A_WIN, 32'd5);
    rd(A_WIN, v);
    check("R10", "window locked", v, 32'd0);
    wr(A_CTRL, 32'h0000FF00);
    rd(A_CTRL, v);
    check("R10", "control locked", v, 32'h0000FF20);
    wr(A_KEY, 32'h0000C520);
    wr(A_KEY, 32'h00001111);
    rd(A_CTRL, v);
    check("R10", "wrong unlock keeps lock", v, 32'h0000FF20);
    wr(A_KEY, 32'h0000C520);
    wr(A_KEY, 32'h0000D928);
    rd(A_CTRL, v);
    check("R10", "unlock clears soft lock", v, 32'h0000FF00);
    wr(A_TO, 32'd50);
    rd(A_TO, v);
    check("R10", "timeout writable after unlock", v, 32'd50);
  endtask

  task automatic t_hard_lock;
    logic [31:0] v;
    do_reset();
    wr(A_CTRL, 32'h0000FF40);
    wr(A_TO, 32'd77);
    rd(A_TO, v);
    check("R11", "timeout locked", v, TO_DEF);
    wr(A_KEY, 32'h0000C520);
    wr(A_KEY, 32'h0000D928);
    rd(A_CTRL, v);
    check("R11", "unlock keys ignored", v, 32'h0000FF40);
    do_reset();
    rd(A_CTRL, v);
    check("R11", "reset clears hard lock", v, 32'h0000FF00);
  endtask

  task automatic t_master;
    logic [31:0] v;
    do_reset();
    wr(A_CTRL, 32'h00000100);
    wr(A_TO, 32'd99, 3'd3);
    check("R12", "write error flag", {31'd0, last_err}, 32'd1);
    rd(A_TO, v, 3'd3);
    check("R12", "read error flag", {31'd0, last_err}, 32'd1);
    check("R12", "refused read data", v, 32'd0);
    rd(A_TO, v, 3'd0);
    check("R12", "enabled master no error", {31'd0, last_err}, 32'd0);
    check("R12", "refused write ignored", v, TO_DEF);
  endtask

  initial begin
    idle(1);
    t_reset_state();
    t_first_irq();
    t_reset_first();
    t_service();
    t_w1c();
    t_window();
    t_debug();
    t_stop();
    t_soft_lock();
    t_hard_lock();
    t_master();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule